// File: doc/BRIEF.md
# Fixed-Priority Partial Crossbar

The block is a switch between three bus masters (a DMA engine, a host port and the CPU) and four single-beat targets. Each master puts one request on its port: a target index, an address, write data and a write flag. Within the same cycle the switch decides which masters are granted. Masters that address different targets all go through together. When two or more masters address the same target, a fixed-priority arbiter chooses the winner. The losing masters hold their request and wait.

A connectivity mask is fixed at elaboration. It lists which master-to-target paths exist. A request on a path that is missing is not routed. It finishes at once with an error flag, and no target sees it. A read that is granted returns its data to the master that issued it one cycle later. The switch forwards the target's data exactly as the target presents it and does not reorder it.

Top module: `xbar_fixed_prio`

## Requirements
- R1: Master index 0 is the DMA engine, 1 is the host port and 2 is the CPU. The 2-bit target field selects target 0 (internal memory), 1 (external memory), 2 (peripheral A) or 3 (peripheral B).
- R2: Masters that request different, reachable targets are all granted in the same cycle.
- R3: When masters contend for one target, only the highest-priority requester is granted. Master 0 beats master 1, and master 1 beats master 2.
- R4: Connectivity mask bit m*4+t enables the path from master m to target t. The default mask is 12'hF3F, so master 1 has no path to targets 2 and 3 and every other path exists.
- R5: A request on a disabled path raises m_err for that master in the same cycle, never raises its m_gnt, and drives no t_sel.
- R6: Grants are combinational. A selected target sees the winner's address, write data and write flag in the grant cycle. Each target is given to at most one master per cycle, and m_gnt is only ever high for a requesting master.
- R7: A master that loses arbitration gets no grant and keeps its request. It is granted later with its own address and data, and none of its transactions is lost.
- R8: For a granted read, m_rvalid and m_rdata appear at that master exactly one cycle after the grant. A write never produces m_rvalid.
- R9: After reset no m_rvalid and no t_sel is active until a request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | NM | Request valid, one bit per master |
| m_tgt | input | NM*TW | Target index per master |
| m_addr | input | NM*AW | Address per master |
| m_wdata | input | NM*DW | Write data per master |
| m_we | input | NM | Write flag per master (1 = write) |
| m_gnt | output | NM | Request accepted this cycle |
| m_err | output | NM | Request refused: path not connected |
| m_rvalid | output | NM | Read data valid |
| m_rdata | output | NM*DW | Read data per master |
| t_sel | output | NT | Target access strobe |
| t_addr | output | NT*AW | Address to each target |
| t_wdata | output | NT*DW | Write data to each target |
| t_we | output | NT | Write flag to each target |
| t_rdata | input | NT*DW | Read data from each target, valid one cycle after its strobe |

## Verification
The stimulus patterns are chosen to separate specific faults:
- Three masters each aimed at a different target tell true parallel routing apart from a switch that serialises its masters.
- All three masters aimed at one target show the order in which the arbiter grants them, and show whether a stalled master's write data survives the wait.
- Host requests to the peripheral targets tell a refused path apart from one that is routed.
- A long pseudo-random mix of reads and writes, compared every cycle against a behavioural model with shadow target memories, catches wrong read-data steering and lost transactions.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int unsigned XB_NUM_MST = 3;
    localparam int unsigned XB_NUM_TGT = 4;

    typedef enum logic [1:0] {
        MST_DMA  = 2'd0,
        MST_HOST = 2'd1,
        MST_CPU  = 2'd2
    } mst_id_e;

    typedef enum logic [1:0] {
        TGT_IMEM = 2'd0,
        TGT_XMEM = 2'd1,
        TGT_PERA = 2'd2,
        TGT_PERB = 2'd3
    } tgt_id_e;

    // bit m*NUM_TGT+t enables master m -> target t; host lacks peripheral paths
    localparam logic [XB_NUM_MST*XB_NUM_TGT-1:0] XB_DEFAULT_CONN = 12'hF3F;
endpackage

// File: rtl/xbar_req_decode.sv
module xbar_req_decode #(
    parameter int unsigned NT = 4,
    parameter int unsigned TW = 2,
    parameter logic [NT-1:0] ROW_CONN = '1
) (
    input  logic          req,
    input  logic [TW-1:0] tgt,
    output logic [NT-1:0] want,
    output logic          err
);
    logic legal;

    always_comb begin
        legal = 1'b0;
        want  = '0;
        for (int t = 0; t < int'(NT); t++) begin
            if (int'(tgt) == t) begin
                legal = ROW_CONN[t];
            end
        end
        for (int t = 0; t < int'(NT); t++) begin
            want[t] = req && legal && (int'(tgt) == t);
        end
        err = req && !legal;
    end
endmodule

// File: rtl/xbar_prio_arb.sv
module xbar_prio_arb #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic taken;

    // index 0 has the highest priority
    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbar_fixed_prio.sv
module xbar_fixed_prio
    import xbar_pkg::*;
#(
    parameter int unsigned NM = XB_NUM_MST,
    parameter int unsigned NT = XB_NUM_TGT,
    parameter int unsigned TW = (NT > 1) ? $clog2(NT) : 1,
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 32,
    parameter logic [NM*NT-1:0] CONN = XB_DEFAULT_CONN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NM-1:0]    m_req,
    input  logic [NM*TW-1:0] m_tgt,
    input  logic [NM*AW-1:0] m_addr,
    input  logic [NM*DW-1:0] m_wdata,
    input  logic [NM-1:0]    m_we,
    output logic [NM-1:0]    m_gnt,
    output logic [NM-1:0]    m_err,
    output logic [NM-1:0]    m_rvalid,
    output logic [NM*DW-1:0] m_rdata,
    output logic [NT-1:0]    t_sel,
    output logic [NT*AW-1:0] t_addr,
    output logic [NT*DW-1:0] t_wdata,
    output logic [NT-1:0]    t_we,
    input  logic [NT*DW-1:0] t_rdata
);
    localparam int unsigned MW = (NM > 1) ? $clog2(NM) : 1;

    typedef struct packed {
        logic [NT-1:0]         rd_pend;
        logic [NT-1:0][MW-1:0] rd_mst;
    } xb_state_t;

    xb_state_t st_d, st_q;

    logic [NT-1:0] want [NM];
    logic [NM-1:0] col  [NT];
    logic [NM-1:0] win  [NT];
    logic [NT-1:0][MW-1:0] win_idx;

    // per-master request decode against the connectivity mask
    for (genvar m = 0; m < NM; m++) begin : g_dec
        xbar_req_decode #(
            .NT(NT), .TW(TW), .ROW_CONN(CONN[m*NT +: NT])
        ) i_dec (
            .req  (m_req[m]),
            .tgt  (m_tgt[m*TW +: TW]),
            .want (want[m]),
            .err  (m_err[m])
        );
    end

    // one fixed-priority arbiter per target
    for (genvar t = 0; t < NT; t++) begin : g_arb
        for (genvar m = 0; m < NM; m++) begin : g_col
            assign col[t][m] = want[m][t];
        end
        xbar_prio_arb #(.N(NM)) i_arb (
            .req (col[t]),
            .gnt (win[t])
        );
    end

    // routing and next-state computation
    always_comb begin
        m_gnt   = '0;
        t_sel   = '0;
        t_addr  = '0;
        t_wdata = '0;
        t_we    = '0;
        win_idx = '0;
        for (int t = 0; t < int'(NT); t++) begin
            for (int m = 0; m < int'(NM); m++) begin
                if (win[t][m]) begin
                    m_gnt[m]             = 1'b1;
                    t_sel[t]             = 1'b1;
                    t_addr[t*AW +: AW]   = m_addr[m*AW +: AW];
                    t_wdata[t*DW +: DW]  = m_wdata[m*DW +: DW];
                    t_we[t]              = m_we[m];
                    win_idx[t]           = MW'(m);
                end
            end
        end
        st_d = st_q;
        for (int t = 0; t < int'(NT); t++) begin
            st_d.rd_pend[t] = t_sel[t] && !t_we[t];
            st_d.rd_mst[t]  = win_idx[t];
        end
    end

    // read response steering from registered route
    always_comb begin
        m_rvalid = '0;
        m_rdata  = '0;
        for (int t = 0; t < int'(NT); t++) begin
            if (st_q.rd_pend[t]) begin
                m_rvalid[st_q.rd_mst[t]]           = 1'b1;
                m_rdata[st_q.rd_mst[t]*DW +: DW]   = t_rdata[t*DW +: DW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xbar_fixed_prio_chk.sv
module xbar_fixed_prio_chk #(
    parameter int unsigned NM = 3,
    parameter int unsigned NT = 4,
    parameter int unsigned TW = 2,
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 32,
    parameter logic [NM*NT-1:0] CONN = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NM-1:0]    m_req,
    input logic [NM*TW-1:0] m_tgt,
    input logic [NM-1:0]    m_we,
    input logic [NM-1:0]    m_gnt,
    input logic [NM-1:0]    m_err,
    input logic [NM-1:0]    m_rvalid
);
    for (genvar m = 0; m < NM; m++) begin : g_m
        p_gnt_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
            m_gnt[m] |-> m_req[m]);
        p_err_no_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
            m_err[m] |-> !m_gnt[m]);
        p_path_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
            m_gnt[m] |-> CONN[m*NT + int'(m_tgt[m*TW +: TW])]);
        p_read_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (m_gnt[m] && !m_we[m]) |=> m_rvalid[m]);
        p_resp_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && m_rvalid[m] |-> $past(m_gnt[m] && !m_we[m]));
        for (genvar n = m + 1; n < NM; n++) begin : g_n
            p_one_per_tgt_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (m_gnt[m] && m_gnt[n]) |-> (m_tgt[m*TW +: TW] != m_tgt[n*TW +: TW]));
            p_prio_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (m_req[m] && !m_err[m] && m_req[n] &&
                 m_tgt[m*TW +: TW] == m_tgt[n*TW +: TW]) |-> !m_gnt[n]);
        end
    end

    p_dma_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req[0] && !m_err[0]) |-> m_gnt[0]);
endmodule

bind xbar_fixed_prio xbar_fixed_prio_chk #(
    .NM(NM), .NT(NT), .TW(TW), .AW(AW), .DW(DW), .CONN(CONN)
) i_chk (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_tgt(m_tgt), .m_we(m_we),
    .m_gnt(m_gnt), .m_err(m_err), .m_rvalid(m_rvalid)
);

// File: tb/test_xbar_fixed_prio.sv
module test_xbar_fixed_prio;
    localparam int NM = 3;
    localparam int NT = 4;
    localparam int TW = 2;
    localparam int AW = 16;
    localparam int DW = 32;

    typedef struct packed {
        logic [1:0]  t;
        logic [3:0]  a;
        logic [31:0] d;
        logic        w;
    } txn_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NM-1:0]    m_req = '0;
    logic [NM*TW-1:0] m_tgt = '0;
    logic [NM*AW-1:0] m_addr = '0;
    logic [NM*DW-1:0] m_wdata = '0;
    logic [NM-1:0]    m_we = '0;
    logic [NM-1:0]    m_gnt, m_err, m_rvalid;
    logic [NM*DW-1:0] m_rdata;
    logic [NT-1:0]    t_sel, t_we;
    logic [NT*AW-1:0] t_addr;
    logic [NT*DW-1:0] t_wdata;
    logic [NT*DW-1:0] t_rdata;

    always #2 clk = ~clk;  // 250 MHz

    xbar_fixed_prio i_xbar_fixed_prio (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_tgt(m_tgt), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_we(m_we), .m_gnt(m_gnt), .m_err(m_err),
        .m_rvalid(m_rvalid), .m_rdata(m_rdata), .t_sel(t_sel), .t_addr(t_addr),
        .t_wdata(t_wdata), .t_we(t_we), .t_rdata(t_rdata)
    );

    // target models: synchronous memories, read data one cycle after strobe
    logic [31:0] tmem [NT][16];
    logic [31:0] trd  [NT];
    always @(posedge clk) begin
        for (int t = 0; t < NT; t++) begin
            if (t_sel[t]) begin
                if (t_we[t]) tmem[t][t_addr[t*AW +: 4]] <= t_wdata[t*DW +: DW];
                else         trd[t] <= tmem[t][t_addr[t*AW +: 4]];
            end
        end
    end
    always_comb begin
        for (int t = 0; t < NT; t++) t_rdata[t*DW +: DW] = trd[t];
    end

    // reference model state
    logic [31:0] rmem [NT][16];
    txn_t mq [NM][$];
    logic [NM-1:0] exp_rv;
    logic [31:0]   exp_rd [NM];
    int checks = 0;
    int errors = 0;
    int saw_all3 = 0;
    int host_err_seen = 0;

    function automatic bit path_ok(int m, int t);
        return !(m == 1 && t >= 2);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        logic [NM-1:0] eg, ee;
        logic [NT-1:0] es;
        logic [NT-1:0] taken;
        logic [NM-1:0] rv_n;
        txn_t h;
        @(negedge clk);
        for (int m = 0; m < NM; m++) begin
            if (mq[m].size() > 0) begin
                h = mq[m][0];
                m_req[m] = 1'b1;
                m_tgt[m*TW +: TW] = h.t;
                m_addr[m*AW +: AW] = {12'h0, h.a};
                m_wdata[m*DW +: DW] = h.d;
                m_we[m] = h.w;
            end else begin
                m_req[m] = 1'b0;
                m_we[m] = 1'b0;
            end
        end
        #1;
        eg = '0; ee = '0; es = '0; taken = '0; rv_n = '0;
        for (int m = 0; m < NM; m++) begin
            if (m_req[m]) begin
                h = mq[m][0];
                if (!path_ok(m, int'(h.t))) ee[m] = 1'b1;
                else if (!taken[h.t]) begin
                    eg[m] = 1'b1; taken[h.t] = 1'b1; es[h.t] = 1'b1;
                end
            end
        end
        check(m_gnt == eg, "R3 grant vector", 32'(m_gnt), 32'(eg));
        check(m_err == ee, "R5 error vector", 32'(m_err), 32'(ee));
        check(t_sel == es, "R6 target strobes", 32'(t_sel), 32'(es));
        check(m_rvalid == exp_rv, "R8 read valid", 32'(m_rvalid), 32'(exp_rv));
        for (int m = 0; m < NM; m++) begin
            if (exp_rv[m])
                check(m_rdata[m*DW +: DW] == exp_rd[m], "R1/R8 read data",
                      m_rdata[m*DW +: DW], exp_rd[m]);
        end
        if (eg == 3'b111) saw_all3++;
        if (ee[1]) host_err_seen++;
        for (int m = 0; m < NM; m++) begin
            if (eg[m]) begin
                h = mq[m].pop_front();
                check(t_addr[h.t*AW +: 4] == h.a && t_we[h.t] == h.w &&
                      (!h.w || t_wdata[h.t*DW +: DW] == h.d),
                      "R6 routed fields", t_wdata[h.t*DW +: DW], h.d);
                if (h.w) rmem[h.t][h.a] = h.d;
                else begin
                    rv_n[m] = 1'b1;
                    exp_rd[m] = rmem[h.t][h.a];
                end
            end else if (ee[m]) begin
                void'(mq[m].pop_front());
            end
        end
        exp_rv = rv_n;
    endtask

    function automatic bit busy();
        return mq[0].size() > 0 || mq[1].size() > 0 || mq[2].size() > 0;
    endfunction

    task automatic drain(output int cyc);
        cyc = 0;
        while (busy()) begin
            step();
            cyc++;
        end
        step();
        step();
    endtask

    function automatic txn_t mk(int t, int a, logic [31:0] d, bit w);
        txn_t x;
        x.t = 2'(t); x.a = 4'(a); x.d = d; x.w = w;
        return x;
    endfunction

    initial begin
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < 16; i++) begin
                tmem[t][i] = 32'hA000_0000 + 32'(t * 256 + i);
                rmem[t][i] = 32'hA000_0000 + 32'(t * 256 + i);
            end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        exp_rv = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check(m_rvalid == '0, "R9 no read valid after reset", 32'(m_rvalid), 0);
        check(t_sel == '0, "R9 no target strobe after reset", 32'(t_sel), 0);
        check(m_gnt == '0, "R9 no grant without request", 32'(m_gnt), 0);

        // R2: three masters, three targets, reads
        mq[0].push_back(mk(0, 3, 0, 0));
        mq[1].push_back(mk(1, 5, 0, 0));
        mq[2].push_back(mk(2, 7, 0, 0));
        drain(cyc);
        check(saw_all3 == 1 && cyc == 1, "R2 parallel grant", 32'(cyc), 1);

        // R3/R7: all three write the same word, then CPU reads it back
        mq[0].push_back(mk(1, 1, 32'h1111_0000, 1));
        mq[1].push_back(mk(1, 1, 32'h2222_0000, 1));
        mq[2].push_back(mk(1, 1, 32'h3333_0000, 1));
        mq[2].push_back(mk(1, 1, 0, 0));
        drain(cyc);
        check(cyc == 4, "R7 stalled masters serialised", 32'(cyc), 4);
        check(tmem[1][1] == 32'h3333_0000, "R7 last writer data kept", tmem[1][1], 32'h3333_0000);

        // R3: host versus CPU with DMA idle
        mq[1].push_back(mk(0, 9, 32'hBEEF_0001, 1));
        mq[2].push_back(mk(0, 9, 32'hBEEF_0002, 1));
        drain(cyc);
        check(tmem[0][9] == 32'hBEEF_0002, "R3 host before CPU", tmem[0][9], 32'hBEEF_0002);

        // R4/R5: host to peripherals is refused, to memory is routed
        mq[1].push_back(mk(2, 0, 32'hDEAD_0002, 1));
        mq[1].push_back(mk(3, 0, 32'hDEAD_0003, 1));
        mq[1].push_back(mk(0, 2, 0, 0));
        drain(cyc);
        check(host_err_seen == 2, "R4 refused host paths", 32'(host_err_seen), 2);
        check(tmem[2][0] == 32'hA000_0200, "R5 no access on refused write", tmem[2][0], 32'hA000_0200);
        check(tmem[3][0] == 32'hA000_0300, "R5 no access on refused write", tmem[3][0], 32'hA000_0300);

        // mixed random traffic
        for (int m = 0; m < NM; m++)
            for (int i = 0; i < 300; i++)
                mq[m].push_back(mk(int'($urandom % 4), int'($urandom % 16), $urandom, $urandom % 2));
        drain(cyc);
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < 16; i++)
                check(tmem[t][i] == rmem[t][i], "R7 final memory image", tmem[t][i], rmem[t][i]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule